// File: doc/BRIEF.md
# ADC Start-Up Zero-Forcing Sequencer

This block sits between a multi-channel audio converter and the serial port that ships its samples out. An active-low power-down input clears it asynchronously. After release it forces every output word to two's complement zero while it counts a fixed number of frame-clock rising edges. It then passes the converter words through unchanged and raises a ready flag. The number of frames depends on the sampling speed class and on whether the port generates its own clocks (master) or receives them (slave).

When the port is a clock master, counting begins as soon as power-down is released. As a slave, the block first waits for a frame-alignment event that depends on the serial format. A justified format needs one frame-clock rising edge. The I2S format needs a frame-clock falling edge, then a bit-clock rising edge, then a bit-clock falling edge. Frame and bit clocks are treated as levels synchronous to the system clock and sampled once per cycle.

The controller has seven named states. The transitions are:

- ARM → COUNT when the role is master.
- ARM → WAIT_FR_RISE when the role is slave with a justified format.
- ARM → WAIT_FR_FALL when the role is slave with I2S.
- WAIT_FR_RISE → COUNT on a frame rise.
- WAIT_FR_FALL → WAIT_BC_RISE on a frame fall.
- WAIT_BC_RISE → WAIT_BC_FALL on a bit rise.
- WAIT_BC_FALL → COUNT on a bit fall.
- COUNT → RUN on the final counted frame rise.
- RUN holds until power-down.
- Power-down returns any state to ARM.

Top module: `adc_init_seq`

## Requirements
- R1: While `pdn_n` is low, `ready` is 0 and every output word is 0, whatever the sample inputs.
- R2: A low pulse on `pdn_n` shorter than one clock period, which no clock edge samples, still clears the sequence. The next count after release starts again from zero.
- R3: The number of counted frames is set by `speed_sel` and the role. Code 0 is normal speed, code 1 is double speed, and codes 2 and 3 are quad speed. Master counts are 4131, 8259 and 16515. Slave counts are 4134, 8262 and 16518.
- R4: The first clock edge after release (state ARM) captures `speed_sel` and `master_mode` and records the clock pin levels. A pin edge is a level that differs from the level recorded at the previous clock edge. No edge is acted on at that first clock edge.
- R5: As master, frame counting starts at the second clock edge after release, with no alignment wait.
- R6: As a slave with `i2s_fmt`=0, the block waits for a frame-clock rising edge. That edge starts timing and is not itself counted.
- R7: As a slave with `i2s_fmt`=1, the block waits for a frame-clock fall, then a bit-clock rise, then a bit-clock fall. That bit-clock fall starts timing.
- R8: In COUNT, each frame-clock rising edge is counted. At the clock edge that detects the final one, `ready` goes to 1 and the output words change from 0 to `smp_in` (channel c at bits c*DW upward), both in the same cycle.
- R9: Once set, `ready` and pass-through stay until `pdn_n` goes low.
- R10: Changes of `speed_sel` or `master_mode` after the capture edge do not change the count until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| pdn_n | input | 1 | Active-low power-down, asynchronous clear |
| frame_clk | input | 1 | Frame clock level, synchronous to clk |
| bit_clk | input | 1 | Bit clock level, synchronous to clk |
| speed_sel | input | 2 | Speed class: 0 normal, 1 double, 2/3 quad |
| master_mode | input | 1 | 1 = port is clock master |
| i2s_fmt | input | 1 | Slave alignment: 1 = I2S, 0 = justified |
| smp_in | input | NCH*DW | Converter words, channel c at bits c*DW upward |
| smp_out | output | NCH*DW | Gated words |
| ready | output | 1 | Initialization complete |

## Verification
A clock-pin level presented just after one clock edge is registered at the next edge. The state change it causes shows up on `ready` and on the gated words in that same cycle, because both are decoded from the state register. The word outputs also follow `smp_in` combinationally with no added delay. The bench therefore drives one nanosecond after each rising edge. It updates its expected state at that edge from the levels standing on the pins, and compares at the following falling edge, so every result is checked exactly in the cycle it is due. The sub-cycle power-down pulse is checked between edges, while no clock has yet sampled it.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_WAIT_FR_RISE,
        ST_WAIT_FR_FALL,
        ST_WAIT_BC_RISE,
        ST_WAIT_BC_FALL,
        ST_COUNT,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'd0,
        SPD_DOUBLE   = 2'd1,
        SPD_QUAD     = 2'd2,
        SPD_QUAD_ALT = 2'd3
    } speed_e;

    typedef struct packed {
        speed_e speed;
        logic   master;
    } seq_cfg_t;

    localparam int unsigned PIN_FRAME = 0;
    localparam int unsigned PIN_BIT   = 1;
    localparam int unsigned NUM_PINS  = 2;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ais_edge_det.sv
module ais_edge_det #(
    parameter int unsigned NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    output logic [NPIN-1:0] rise,
    output logic [NPIN-1:0] fall
);

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            logic prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                end else begin
                    prev_q <= pin[i];
                end
            end

            assign rise[i] = pin[i] & ~prev_q;
            assign fall[i] = ~pin[i] & prev_q;
        end
    endgenerate

endmodule

// File: rtl/ais_frame_counter.sv
module ais_frame_counter
    import ais_pkg::*;
#(
    parameter int unsigned CW         = 15,
    parameter int unsigned CNT_NS_MST = 4131,
    parameter int unsigned CNT_DS_MST = 8259,
    parameter int unsigned CNT_QS_MST = 16515,
    parameter int unsigned CNT_NS_SLV = 4134,
    parameter int unsigned CNT_DS_SLV = 8262,
    parameter int unsigned CNT_QS_SLV = 16518
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     tick,
    input  seq_cfg_t cfg,
    output logic     done
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;

    // target frame count from captured speed class and role
    always_comb begin
        unique case (cfg.speed)
            SPD_NORMAL: target = cfg.master ? CW'(CNT_NS_MST) : CW'(CNT_NS_SLV);
            SPD_DOUBLE: target = cfg.master ? CW'(CNT_DS_MST) : CW'(CNT_DS_SLV);
            default:    target = cfg.master ? CW'(CNT_QS_MST) : CW'(CNT_QS_SLV);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == target - 1'b1);

endmodule

// File: rtl/ais_word_gate.sv
module ais_word_gate #(
    parameter int unsigned DW  = 24,
    parameter int unsigned NCH = 2
) (
    input  logic              pass,
    input  logic [NCH*DW-1:0] din,
    output logic [NCH*DW-1:0] dout
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            assign dout[c*DW +: DW] = pass ? din[c*DW +: DW] : '0;
        end
    endgenerate

endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
    import ais_pkg::*;
#(
    parameter int unsigned DW         = 24,
    parameter int unsigned NCH        = 2,
    parameter int unsigned CNT_NS_MST = 4131,
    parameter int unsigned CNT_DS_MST = 8259,
    parameter int unsigned CNT_QS_MST = 16515,
    parameter int unsigned CNT_NS_SLV = 4134,
    parameter int unsigned CNT_DS_SLV = 8262,
    parameter int unsigned CNT_QS_SLV = 16518
) (
    input  logic              clk,
    input  logic              pdn_n,
    input  logic              frame_clk,
    input  logic              bit_clk,
    input  logic [1:0]        speed_sel,
    input  logic              master_mode,
    input  logic              i2s_fmt,
    input  logic [NCH*DW-1:0] smp_in,
    output logic [NCH*DW-1:0] smp_out,
    output logic              ready
);

    localparam int unsigned CNT_MAX = umax(umax(umax(CNT_NS_MST, CNT_DS_MST), umax(CNT_QS_MST, CNT_NS_SLV)),
                                           umax(CNT_DS_SLV, CNT_QS_SLV));
    localparam int unsigned CNT_MIN = umin(umin(umin(CNT_NS_MST, CNT_DS_MST), umin(CNT_QS_MST, CNT_NS_SLV)),
                                           umin(CNT_DS_SLV, CNT_QS_SLV));
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    seq_state_e          state_q, state_d;
    seq_cfg_t            cfg_q;
    logic [NUM_PINS-1:0] pins, pin_rise, pin_fall;
    logic                count_en, cnt_done, pass_en;

    assign pins[PIN_FRAME] = frame_clk;
    assign pins[PIN_BIT]   = bit_clk;

    ais_edge_det #(.NPIN(NUM_PINS)) u_edges (
        .clk   (clk),
        .rst_n (pdn_n),
        .pin   (pins),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    // state register
    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // configuration captured on the arming edge
    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            cfg_q <= '{speed: SPD_NORMAL, master: 1'b0};
        end else if (state_q == ST_ARM) begin
            cfg_q <= '{speed: speed_e'(speed_sel), master: master_mode};
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: begin
                if (master_mode)  state_d = ST_COUNT;
                else if (i2s_fmt) state_d = ST_WAIT_FR_FALL;
                else              state_d = ST_WAIT_FR_RISE;
            end
            ST_WAIT_FR_RISE: if (pin_rise[PIN_FRAME]) state_d = ST_COUNT;
            ST_WAIT_FR_FALL: if (pin_fall[PIN_FRAME]) state_d = ST_WAIT_BC_RISE;
            ST_WAIT_BC_RISE: if (pin_rise[PIN_BIT])   state_d = ST_WAIT_BC_FALL;
            ST_WAIT_BC_FALL: if (pin_fall[PIN_BIT])   state_d = ST_COUNT;
            ST_COUNT:        if (cnt_done)            state_d = ST_RUN;
            ST_RUN:          state_d = ST_RUN;
            default:         state_d = ST_ARM;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        count_en = 1'b0;
        pass_en  = 1'b0;
        unique case (state_q)
            ST_COUNT: count_en = 1'b1;
            ST_RUN:   pass_en  = 1'b1;
            default: ;
        endcase
    end

    assign ready = pass_en;

    ais_frame_counter #(
        .CW         (CW),
        .CNT_NS_MST (CNT_NS_MST),
        .CNT_DS_MST (CNT_DS_MST),
        .CNT_QS_MST (CNT_QS_MST),
        .CNT_NS_SLV (CNT_NS_SLV),
        .CNT_DS_SLV (CNT_DS_SLV),
        .CNT_QS_SLV (CNT_QS_SLV)
    ) u_count (
        .clk   (clk),
        .rst_n (pdn_n),
        .run   (count_en),
        .tick  (pin_rise[PIN_FRAME]),
        .cfg   (cfg_q),
        .done  (cnt_done)
    );

    ais_word_gate #(.DW(DW), .NCH(NCH)) u_gate (
        .pass (pass_en),
        .din  (smp_in),
        .dout (smp_out)
    );

endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
    parameter int unsigned DW      = 24,
    parameter int unsigned NCH     = 2,
    parameter int unsigned MIN_CNT = 4131
) (
    input logic              clk,
    input logic              pdn_n,
    input logic              frame_clk,
    input logic [NCH*DW-1:0] smp_in,
    input logic [NCH*DW-1:0] smp_out,
    input logic              ready
);

    logic        fr_prev;
    logic [31:0] rises_seen;

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            fr_prev    <= 1'b0;
            rises_seen <= '0;
        end else begin
            fr_prev <= frame_clk;
            if (frame_clk && !fr_prev) rises_seen <= rises_seen + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (pdn_n === 1'b0) begin
            assert_pd_clear_R1: assert (ready == 1'b0 && smp_out == '0);
        end
    end

    assert_gate_zero_R8: assert property (@(posedge clk) disable iff (!pdn_n)
        !ready |-> smp_out == '0);

    assert_gate_pass_R8: assert property (@(posedge clk) disable iff (!pdn_n)
        ready |-> smp_out == smp_in);

    assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!pdn_n)
        ready |=> ready);

    assert_ready_on_frame_rise_R8: assert property (@(posedge clk) disable iff (!pdn_n)
        $rose(ready) |-> ($past(frame_clk) && !$past(frame_clk, 2)));

    assert_min_frames_R3: assert property (@(posedge clk) disable iff (!pdn_n)
        $rose(ready) |-> rises_seen >= MIN_CNT);

endmodule

bind adc_init_seq adc_init_seq_chk #(
    .DW      (DW),
    .NCH     (NCH),
    .MIN_CNT (CNT_MIN)
) u_chk (
    .clk       (clk),
    .pdn_n     (pdn_n),
    .frame_clk (frame_clk),
    .smp_in    (smp_in),
    .smp_out   (smp_out),
    .ready     (ready)
);

// File: tb/adc_init_seq_bench.sv
module adc_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int NCH        = 2;
    localparam int W          = DW * NCH;

    logic         clk = 1'b0;
    logic         pdn_n = 1'b0;
    logic         frame_clk = 1'b0;
    logic         bit_clk = 1'b0;
    logic [1:0]   speed_sel = 2'd0;
    logic         master_mode = 1'b0;
    logic         i2s_fmt = 1'b0;
    logic [W-1:0] smp_in = '0;
    logic [W-1:0] smp_out;
    logic         ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_init_seq #(.DW(DW), .NCH(NCH)) u_adc_init_seq (
        .clk         (clk),
        .pdn_n       (pdn_n),
        .frame_clk   (frame_clk),
        .bit_clk     (bit_clk),
        .speed_sel   (speed_sel),
        .master_mode (master_mode),
        .i2s_fmt     (i2s_fmt),
        .smp_in      (smp_in),
        .smp_out     (smp_out),
        .ready       (ready)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic         exp_rdy_q[$];
    logic [W-1:0] exp_word_q[$];
    string        exp_tag_q[$];

    // reference model: 0 idle, 1 wait frame rise, 2 wait frame fall,
    // 3 wait bit rise, 4 wait bit fall, 5 counting, 6 done
    int          m_ph = 0;
    bit          m_first = 1;
    int          m_cnt = 0;
    int          m_tgt = 0;
    logic        m_pf = 1'b0;
    logic        m_pb = 1'b0;
    int unsigned g_ph = 0;

    function automatic int frames_for(input logic [1:0] s, input logic m);
        if (m) return (s == 2'd0) ? 4131 : (s == 2'd1) ? 8259 : 16515;
        return (s == 2'd0) ? 4134 : (s == 2'd1) ? 8262 : 16518;
    endfunction

    task automatic model_clear();
        m_first = 1;
        m_ph    = 0;
        m_cnt   = 0;
    endtask

    task automatic model_edge();
        if (!pdn_n) begin
            model_clear();
        end else if (m_first) begin
            m_first = 0;
            m_tgt   = frames_for(speed_sel, master_mode);
            m_cnt   = 0;
            m_ph    = master_mode ? 5 : (i2s_fmt ? 2 : 1);
        end else begin
            case (m_ph)
                1: if (frame_clk && !m_pf) m_ph = 5;
                2: if (!frame_clk && m_pf) m_ph = 3;
                3: if (bit_clk && !m_pb) m_ph = 4;
                4: if (!bit_clk && m_pb) m_ph = 5;
                5: if (frame_clk && !m_pf) begin
                       m_cnt++;
                       if (m_cnt == m_tgt) m_ph = 6;
                   end
                default: ;
            endcase
        end
        m_pf = frame_clk;
        m_pb = bit_clk;
    endtask

    task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one clock cycle of stimulus, pushes the expected outputs
    task automatic cyc(input logic p, input string tag);
        logic [W-1:0] w;
        @(posedge clk);
        model_edge();
        #1;
        g_ph++;
        w = {24'(g_ph * 7 + 24'h5A5A01), 24'(g_ph * 13 + 24'h010203)};
        pdn_n     = p;
        frame_clk = g_ph[1];
        bit_clk   = g_ph[0];
        smp_in    = w;
        if (!p) model_clear();
        exp_rdy_q.push_back(m_ph == 6);
        exp_word_q.push_back((m_ph == 6) ? w : '0);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin : mon
        logic         r;
        logic [W-1:0] wd;
        string        t;
        if (exp_rdy_q.size() > 0) begin
            r  = exp_rdy_q.pop_front();
            wd = exp_word_q.pop_front();
            t  = exp_tag_q.pop_front();
            check(ready === r && smp_out === wd, t, {ready, smp_out}, {r, wd});
        end
    end

    task automatic run_to_ready(input string tag, input string tag_after);
        while (m_ph != 6) cyc(1'b1, tag);
        repeat (16) cyc(1'b1, tag_after);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R1: reset state
        repeat (5) cyc(1'b0, "R1 reset");

        // master, normal speed; speed changed mid-count (R10)
        master_mode = 1'b1;
        speed_sel   = 2'd0;
        repeat (2000) cyc(1'b1, "R3 R5 master normal");
        speed_sel = 2'd2;
        run_to_ready("R3 R8 R10 master normal, late speed change", "R8 R9 master normal pass");

        // partial count, sub-cycle power-down pulse, slave justified double
        repeat (2) cyc(1'b0, "R1 pd");
        speed_sel = 2'd0;
        repeat (400) cyc(1'b1, "R5 partial count");
        while (g_ph[1:0] != 2'b10) cyc(1'b1, "R5 partial count");
        @(negedge clk);
        #1 pdn_n = 1'b0;
        #1 check(ready === 1'b0 && smp_out === '0, "R2 short pulse clears",
                 {ready, smp_out}, '0);
        master_mode = 1'b0;
        i2s_fmt     = 1'b0;
        speed_sel   = 2'd1;
        #1 pdn_n = 1'b1;
        model_clear();
        run_to_ready("R2 R3 R4 R6 slave justified double", "R8 R9 slave justified pass");

        // slave I2S normal speed
        repeat (3) cyc(1'b0, "R1 pd");
        master_mode = 1'b0;
        i2s_fmt     = 1'b1;
        speed_sel   = 2'd0;
        run_to_ready("R3 R7 slave i2s normal", "R8 R9 slave i2s pass");

        // master quad speed
        repeat (3) cyc(1'b0, "R1 pd");
        master_mode = 1'b1;
        i2s_fmt     = 1'b0;
        speed_sel   = 2'd2;
        run_to_ready("R3 R5 master quad", "R8 R9 master quad pass");

        repeat (2) cyc(1'b0, "R1 final pd");
        @(negedge clk);
        #1;
        report();
    end

endmodule